// File: doc/BRIEF.md
# Paired-channel sample/hold sequencer

This block paces a dual-channel converter that captures two inputs at once. A start pulse can come from three places: a PWM event, a software write, or an external pin. The block latches a 3-bit pair index and a 4-bit acquisition length, and after a fixed delay it drives a sample/hold pulse. The two inputs that share the index are captured together on the pulse's falling edge. The A and B values then move through a short latency line into two result registers, B one converter clock after A. A flag rises a fixed number of cycles after the B write and stays high until it is cleared.

Everything runs on one clock, `clk`, at twice the converter clock rate, so all intervals below are counted in `clk` cycles (one cycle is half a converter clock). With continuous operation enabled, pulses repeat without further starts. A converter model sits inside the block: for each channel of the selected pair, it returns the value present at the capture edge.

Top module: `pair_sample_seq`

## Requirements
- R1: A start is any one of `trig_pwm`, `trig_sw` or `trig_ext` sampled high at a rising clock edge while the sequencer is idle; each source alone starts a conversion.
- R2: `sh_pulse` goes high at the 5th rising edge after the edge that accepted the start.
- R3: `sh_pulse` stays high for 2*(1+ACQ) cycles, where ACQ is the value of `acq_len` (0 to 15) latched with the start.
- R4: The pair index `ch_sel` is latched with the start. Index i selects `ain_a[12*i+11:12*i]` and `ain_b[12*i+11:12*i]`.
- R5: Both selected inputs are captured at the rising edge where `sh_pulse` falls, with the values they held in the cycle just before that edge.
- R6: `res_a` takes the captured A value 8 cycles after the capture edge, and `res_b` takes the B value 10 cycles after it. Neither changes earlier.
- R7: If `cont_en` is high at the capture edge, the next `sh_pulse` rises 4 cycles after the fall. Pulses and result writes of each channel then repeat every 2*(3+ACQ) cycles with the latched index and length. If `cont_en` is low at a capture edge, the sequence stops after that pulse.
- R8: Start inputs, `ch_sel` and `acq_len` have no effect while the sequencer is busy, that is, in the start delay, during the pulse, or in the gap between continuous pulses.
- R9: `irq_flag` rises 2 cycles after the `res_b` write and holds until `irq_clr` is sampled high. A set and a clear in the same cycle leave the flag set.
- R10: After reset, `sh_pulse`, `res_a`, `res_b` and `irq_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pwm | input | 1 | Start request from a PWM event |
| trig_sw | input | 1 | Start request from a software write |
| trig_ext | input | 1 | Start request from an external pin |
| cont_en | input | 1 | Repeat pulses while high |
| ch_sel | input | 3 | Pair index, latched at start |
| acq_len | input | 4 | Acquisition length ACQ, latched at start |
| ain_a | input | 96 | Eight 12-bit A-channel inputs, index i at bits 12*i+11:12*i |
| ain_b | input | 96 | Eight 12-bit B-channel inputs, same layout |
| irq_clr | input | 1 | Write-one-to-clear for the flag |
| sh_pulse | output | 1 | Sample/hold pulse |
| res_a | output | 12 | A-channel result register |
| res_b | output | 12 | B-channel result register |
| irq_flag | output | 1 | Result-ready flag |

## Verification
The flag's set and its clear can land on the same edge. The bench provokes this by raising `irq_clr` for exactly the cycle that the set, counted from the capture edge, falls on. It then requires the flag to read high after that edge and to stay high until a later, lone clear. A second collision occurs in continuous mode with ACQ 0: the next capture edge comes before the previous sample's result writes. The bench requires every result to carry the input pattern from the cycle before its own capture edge. The inputs change every cycle, so a mix-up between samples shows up.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_HOLD = 2'd2,
      SQ_GAP  = 2'd3
   } sq_state_e;

   // converts a span in converter clocks into clk cycles
   function automatic int unsigned adc_to_ticks(input int unsigned adc_clks,
                                                input int unsigned tpc);
      return adc_clks * tpc;
   endfunction

endpackage

// File: rtl/pss_timer.sv
`timescale 1ns/1ps
module pss_timer
   import pss_pkg::*;
#(
   parameter int unsigned ACQW  = 4,
   parameter int unsigned SELW  = 3,
   parameter int unsigned TPC   = 2,
   parameter int unsigned DLY_T = 5,
   parameter int unsigned GAP_T = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig,
   input  logic            cont_en,
   input  logic [SELW-1:0] ch_sel,
   input  logic [ACQW-1:0] acq_len,
   output logic            sh,
   output logic            sh_end,
   output logic [SELW-1:0] sel_q
);

   localparam int unsigned MAXW = TPC * (1 << ACQW);
   localparam int unsigned CW   = $clog2(MAXW + DLY_T + GAP_T + 1);

   sq_state_e      st_q;
   logic [CW-1:0]  cnt_q;
   logic [CW-1:0]  w_q;
   logic [CW-1:0]  lim;
   logic           last;

   always_comb begin
      unique case (st_q)
         SQ_WAIT: lim = CW'(DLY_T - 1);
         SQ_HOLD: lim = w_q - 1'b1;
         SQ_GAP:  lim = CW'(GAP_T - 1);
         default: lim = '0;
      endcase
   end

   assign last   = (cnt_q == lim);
   assign sh     = (st_q == SQ_HOLD);
   assign sh_end = sh && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
         w_q   <= '0;
         sel_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (trig) begin
               st_q  <= SQ_WAIT;
               cnt_q <= '0;
               sel_q <= ch_sel;
               w_q   <= CW'(TPC * (int'(acq_len) + 1));
            end
            SQ_WAIT: if (last) begin
               st_q  <= SQ_HOLD;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            SQ_HOLD: if (last) begin
               st_q  <= cont_en ? SQ_GAP : SQ_IDLE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            SQ_GAP: if (last) begin
               st_q  <= SQ_HOLD;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // independent measure of the pulse length
   logic [CW-1:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hi_len <= '0;
      else if (sh) hi_len <= hi_len + 1'b1;
      else         hi_len <= '0;
   end

   AST_SH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sh) |-> hi_len == w_q); // R3
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SQ_IDLE && trig) |=> $stable(sel_q) && $stable(w_q)); // R8
   AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE && trig) |=> (st_q == SQ_WAIT && sel_q == $past(ch_sel))); // R4

endmodule

// File: rtl/pss_capture.sv
`timescale 1ns/1ps
module pss_capture #(
   parameter int unsigned DW    = 12,
   parameter int unsigned NPAIR = 8,
   parameter int unsigned SELW  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [SELW-1:0]     sel,
   input  logic [NPAIR*DW-1:0] ain_a,
   input  logic [NPAIR*DW-1:0] ain_b,
   output logic                out_v,
   output logic [DW-1:0]       out_a,
   output logic [DW-1:0]       out_b
);

   logic [DW-1:0] a_arr [NPAIR];
   logic [DW-1:0] b_arr [NPAIR];

   for (genvar i = 0; i < NPAIR; i++) begin : g_ch
      assign a_arr[i] = ain_a[i*DW +: DW];
      assign b_arr[i] = ain_b[i*DW +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         out_a <= '0;
         out_b <= '0;
      end else begin
         out_v <= take;
         if (take) begin
            out_a <= a_arr[sel];
            out_b <= b_arr[sel];
         end
      end
   end

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(out_a) && $stable(out_b)); // R5

endmodule

// File: rtl/pss_result.sv
`timescale 1ns/1ps
module pss_result #(
   parameter int unsigned DW      = 12,
   parameter int unsigned LAT_A_T = 8,
   parameter int unsigned LAT_B_T = 10,
   parameter int unsigned IRQ_T   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   input  logic          irq_clr,
   output logic [DW-1:0] res_a,
   output logic [DW-1:0] res_b,
   output logic          irq_flag
);

   // element j holds the sample one cycle older than element j-1
   localparam int unsigned NLN = LAT_B_T + IRQ_T - 1;

   logic          ln_v [NLN];
   logic [DW-1:0] ln_a [NLN];
   logic [DW-1:0] ln_b [NLN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NLN; k++) begin
            ln_v[k] <= 1'b0;
            ln_a[k] <= '0;
            ln_b[k] <= '0;
         end
      end else begin
         ln_v[0] <= in_v;
         if (in_v) begin
            ln_a[0] <= in_a;
            ln_b[0] <= in_b;
         end
         for (int k = 1; k < NLN; k++) begin
            ln_v[k] <= ln_v[k-1];
            if (ln_v[k-1]) begin
               ln_a[k] <= ln_a[k-1];
               ln_b[k] <= ln_b[k-1];
            end
         end
      end
   end

   logic          a_go;
   logic [DW-1:0] a_src;
   logic          b_go;
   logic [DW-1:0] b_src;
   logic          irq_set;

   if (LAT_A_T == 1) begin : g_a_direct
      assign a_go  = in_v;
      assign a_src = in_a;
   end else begin : g_a_tap
      assign a_go  = ln_v[LAT_A_T-2];
      assign a_src = ln_a[LAT_A_T-2];
   end

   assign b_go    = ln_v[LAT_B_T-2];
   assign b_src   = ln_b[LAT_B_T-2];
   assign irq_set = ln_v[NLN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_a    <= '0;
         res_b    <= '0;
         irq_flag <= 1'b0;
      end else begin
         if (a_go) res_a <= a_src;
         if (b_go) res_b <= b_src;
         if (irq_set)      irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
      end
   end

   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq_flag); // R9
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_set) |=> !irq_flag); // R9
   AST_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !b_go |=> $stable(res_b)); // R6

endmodule

// File: rtl/pair_sample_seq.sv
`timescale 1ns/1ps
module pair_sample_seq
   import pss_pkg::*;
#(
   parameter int unsigned DW        = 12,
   parameter int unsigned NPAIR     = 8,
   parameter int unsigned ACQW      = 4,
   parameter int unsigned TPC       = 2,
   parameter int unsigned DLY_HALF  = 5,
   parameter int unsigned GAP_ADC   = 2,
   parameter int unsigned LAT_A_ADC = 4,
   parameter int unsigned LAT_B_ADC = 5,
   parameter int unsigned IRQ_T     = 2,
   localparam int unsigned SELW     = $clog2(NPAIR)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_pwm,
   input  logic                trig_sw,
   input  logic                trig_ext,
   input  logic                cont_en,
   input  logic [SELW-1:0]     ch_sel,
   input  logic [ACQW-1:0]     acq_len,
   input  logic [NPAIR*DW-1:0] ain_a,
   input  logic [NPAIR*DW-1:0] ain_b,
   input  logic                irq_clr,
   output logic                sh_pulse,
   output logic [DW-1:0]       res_a,
   output logic [DW-1:0]       res_b,
   output logic                irq_flag
);

   localparam int unsigned DLY_T   = DLY_HALF * TPC / 2;
   localparam int unsigned GAP_T   = adc_to_ticks(GAP_ADC, TPC);
   localparam int unsigned LAT_A_T = adc_to_ticks(LAT_A_ADC, TPC);
   localparam int unsigned LAT_B_T = adc_to_ticks(LAT_B_ADC, TPC);

   if (TPC == 0 || (TPC % 2) != 0) begin : g_bad_tpc
      $error("TPC must be a nonzero even count");
   end
   if (NPAIR != (1 << SELW) || NPAIR < 2) begin : g_bad_npair
      $error("NPAIR must be a power of two of at least 2");
   end
   if (DLY_T == 0 || GAP_T == 0 || IRQ_T == 0) begin : g_bad_delay
      $error("delay, gap and flag delay must be nonzero");
   end
   if (LAT_A_T == 0 || LAT_B_T <= LAT_A_T) begin : g_bad_lat
      $error("B latency must exceed a nonzero A latency");
   end

   logic            trig_any;
   logic            sh_end;
   logic [SELW-1:0] sel_q;
   logic            cap_v;
   logic [DW-1:0]   cap_a;
   logic [DW-1:0]   cap_b;

   assign trig_any = trig_pwm | trig_sw | trig_ext;

   pss_timer #(
      .ACQW (ACQW), .SELW (SELW), .TPC (TPC), .DLY_T (DLY_T), .GAP_T (GAP_T)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig_any),
      .cont_en (cont_en),
      .ch_sel  (ch_sel),
      .acq_len (acq_len),
      .sh      (sh_pulse),
      .sh_end  (sh_end),
      .sel_q   (sel_q)
   );

   pss_capture #(
      .DW (DW), .NPAIR (NPAIR), .SELW (SELW)
   ) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (sh_end),
      .sel   (sel_q),
      .ain_a (ain_a),
      .ain_b (ain_b),
      .out_v (cap_v),
      .out_a (cap_a),
      .out_b (cap_b)
   );

   pss_result #(
      .DW (DW), .LAT_A_T (LAT_A_T), .LAT_B_T (LAT_B_T), .IRQ_T (IRQ_T)
   ) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (cap_v),
      .in_a     (cap_a),
      .in_b     (cap_b),
      .irq_clr  (irq_clr),
      .res_a    (res_a),
      .res_b    (res_b),
      .irq_flag (irq_flag)
   );

   AST_NO_SH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sh_pulse) && !cont_en) |-> !$past(trig_any)); // R2

endmodule

// File: tb/pair_sample_seq_test.sv
`timescale 1ns/1ps
module pair_sample_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_pwm = 1'b0, trig_sw = 1'b0, trig_ext = 1'b0;
   logic        cont_en = 1'b0;
   logic [2:0]  ch_sel = '0;
   logic [3:0]  acq_len = '0;
   logic [95:0] ain_a = '0, ain_b = '0;
   logic        irq_clr = 1'b0;
   logic        sh_pulse, irq_flag;
   logic [11:0] res_a, res_b;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   logic [11:0] prev_a = '0, prev_b = '0;

   pair_sample_seq uut (
      .clk (clk), .rst_n (rst_n), .trig_pwm (trig_pwm), .trig_sw (trig_sw),
      .trig_ext (trig_ext), .cont_en (cont_en), .ch_sel (ch_sel),
      .acq_len (acq_len), .ain_a (ain_a), .ain_b (ain_b), .irq_clr (irq_clr),
      .sh_pulse (sh_pulse), .res_a (res_a), .res_b (res_b), .irq_flag (irq_flag)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [11:0] pa(input int c, input int i);
      return 12'((c * 37 + i * 5 + 1) & 4095);
   endfunction
   function automatic logic [11:0] pb(input int c, input int i);
      return 12'((c * 53 + i * 11 + 7) & 4095);
   endfunction

   // inputs change every cycle so the capture instant is visible
   always @(negedge clk) begin
      for (int i = 0; i < 8; i++) begin
         ain_a[i*12 +: 12] <= pa(cyc, i);
         ain_b[i*12 +: 12] <= pb(cyc, i);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic drop_drives();
      trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic fire(input int src);
      if (src == 0) trig_pwm = 1'b1;
      else if (src == 1) trig_sw = 1'b1;
      else trig_ext = 1'b1;
   endtask

   task automatic clear_flag();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq_flag == 1'b0, "R9 clear", irq_flag, 0);
   endtask

   task automatic run_single(input int src, input int acq, input int sel,
                             input bit noise, input bit collide);
      int e0, w, f, bad;
      logic [11:0] ea, eb;
      @(negedge clk);
      drop_drives();
      ch_sel = 3'(sel); acq_len = 4'(acq); cont_en = 1'b0;
      fire(src);
      e0 = cyc + 1; w = 2 * (1 + acq); f = e0 + 5 + w;
      ea = pa(f - 1, sel); eb = pb(f - 1, sel);
      bad = 0;
      while (cyc < f + 14) begin
         @(negedge clk);
         drop_drives();
         if (noise && (cyc == e0 + 1 || cyc == e0 + 6)) begin
            trig_sw = 1'b1; ch_sel = 3'(sel ^ 1); acq_len = 4'((acq + 5) & 15);
         end
         if (collide && cyc == f + 11) irq_clr = 1'b1;
         if ((cyc >= e0 + 5 && cyc < f) != sh_pulse) bad++;
         if (cyc == f + 7)  chk(res_a == prev_a, "R6 A not early", res_a, prev_a);
         if (cyc == f + 8)  chk(res_a == ea, "R4 R5 R6 A value", res_a, ea);
         if (cyc == f + 9)  chk(res_b == prev_b, "R6 B not early", res_b, prev_b);
         if (cyc == f + 10) chk(res_b == eb, "R4 R5 R6 B value", res_b, eb);
         if (cyc == f + 11) chk(irq_flag == 1'b0, "R9 flag not early", irq_flag, 0);
         if (cyc == f + 12) chk(irq_flag == 1'b1, "R9 flag set, wins over clear", irq_flag, 1);
         if (cyc == f + 14) chk(irq_flag == 1'b1, "R9 flag held", irq_flag, 1);
      end
      // R1 R2 R3 pulse placement; with noise also R8
      chk(bad == 0, noise ? "R8 R2 R3 pulse timing" : "R1 R2 R3 pulse timing", bad, 0);
      prev_a = ea; prev_b = eb;
      clear_flag();
   endtask

   task automatic run_cont(input int src, input int acq, input int sel);
      int e0, w, p, bad, ex;
      int fk [3];
      logic [11:0] la, lb;
      @(negedge clk);
      drop_drives();
      ch_sel = 3'(sel); acq_len = 4'(acq); cont_en = 1'b1;
      fire(src);
      e0 = cyc + 1; w = 2 * (1 + acq); p = 2 * (3 + acq);
      for (int k = 0; k < 3; k++) fk[k] = e0 + 5 + w + k * p;
      bad = 0; la = prev_a; lb = prev_b;
      while (cyc < fk[2] + 16) begin
         @(negedge clk);
         drop_drives();
         if (cyc == fk[1]) cont_en = 1'b0;
         if (cyc == fk[0] + 1) begin
            trig_ext = 1'b1; ch_sel = 3'(sel ^ 3);   // lands in the gap, R8
         end
         ex = 0;
         for (int k = 0; k < 3; k++) if (cyc >= fk[k] - w && cyc < fk[k]) ex = 1;
         if (ex != int'(sh_pulse)) bad++;
         for (int k = 0; k < 3; k++) begin
            if (cyc == fk[k] + 8) begin
               la = pa(fk[k] - 1, sel);
               chk(res_a == la, "R7 R5 repeated A value", res_a, la);
            end
            if (cyc == fk[k] + 10) begin
               lb = pb(fk[k] - 1, sel);
               chk(res_b == lb, "R7 R5 repeated B value", res_b, lb);
            end
         end
      end
      chk(bad == 0, "R7 R8 continuous pulse train", bad, 0);
      prev_a = la; prev_b = lb;
      clear_flag();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sh_pulse == 1'b0, "R10 sh reset", sh_pulse, 0);
      chk(res_a == 12'd0, "R10 res_a reset", res_a, 0);
      chk(res_b == 12'd0, "R10 res_b reset", res_b, 0);
      chk(irq_flag == 1'b0, "R10 flag reset", irq_flag, 0);
      for (int acq = 0; acq < 16; acq++)
         run_single(acq % 3, acq, acq % 8, (acq % 4) == 1, (acq % 4) == 2);
      for (int sel = 0; sel < 8; sel++)
         run_single(sel % 3, 3, sel, (sel % 2) == 1, 1'b1);
      run_cont(0, 0, 5);
      run_cont(1, 2, 6);
      run_cont(2, 15, 2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule